// File: doc/BRIEF.md
# Read Cycle Cacheability Sampler

This block lives in a processor bus interface and decides, once per bus cycle, whether the data returned by a memory read may be written into the on-chip cache. System logic drives an external cache-enable pin. The block latches that pin a single time per read, on the earliest strobe that marks the data phase. After that, later beats of a burst cannot change the decision.

Whether a capture happens depends on several things. The cycle type, the lock attribute and the address-hold level are all recorded at cycle start. The processor power state and a group of hold, backoff, reset and probe controls are checked live. A backoff throws away any capture already taken, so the restarted cycle samples the pin again.

The captured enable is combined with the internal cache-request indication, the page write-through bit and the external writeback/writethrough input. The result is a cacheable-fill flag and a hint for the state of the line that is filled.

Top module: `rdfill_qualifier`

## Requirements
- R1: After reset, `sampled` is 0, `fill_ok` is 0 and `fill_state` is 0 (no fill).
- R2: `ext_cen` is captured at the first rising edge where `data_rdy` or `next_addr` is high for an eligible cycle. Later strobes in the same cycle do not change the captured value, and this holds even when both strobes arrive together. A strobe in the same clock as `cyc_start` is not allowed.
- R3: If the captured enable is 0, then `fill_ok` is 0 and `fill_state` is 0 (no fill), whatever the other inputs are.
- R4: If the captured enable is 1 and `cache_req` is 1, then `fill_ok` is 1. `fill_state` is 1 (Shared) when `page_wt` is 1 or `ext_wbwt` is 0 (writethrough), and 2 (Exclusive) otherwise. If `cache_req` is 0, then `fill_ok` is 0 and `fill_state` is 0.
- R5: Only memory reads are sampled (`cyc_kind` 0). Memory write (1), inquire (2), I/O (3), special (4) and interrupt acknowledge (5) are never sampled. A read with `cyc_locked` high is never sampled either.
- R6: Sampling is allowed in `pwr_state` 0 (normal) and 1 (system management). It is blocked in 2 (halt), 3 (shutdown), 4 (stop grant) and 5 (stop clock).
- R7: No capture occurs in a clock where any of `backoff`, `hold_ack`, `sys_reset`, `sys_init` or `probe_rdy` is high. A later unblocked strobe in the same cycle still captures.
- R8: A cycle that starts while `addr_hold` is low may be sampled even after `addr_hold` rises. A cycle that starts while `addr_hold` is high is never sampled.
- R9: `cyc_start` clears the capture, so `sampled` is 0 in the clock after it.
- R10: A `backoff` clears a capture already taken, so `sampled` is 0 after it. The restarted cycle then captures the pin again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cyc_start | input | 1 | One-clock pulse that opens a new bus cycle |
| cyc_kind | input | 3 | Cycle type, sampled at `cyc_start` |
| cyc_locked | input | 1 | Locked-cycle attribute, sampled at `cyc_start` |
| pwr_state | input | 3 | Processor power state |
| data_rdy | input | 1 | Data-ready strobe |
| next_addr | input | 1 | Next-address strobe |
| backoff | input | 1 | Bus backoff |
| hold_ack | input | 1 | Hold acknowledge |
| sys_reset | input | 1 | Processor reset pin level |
| sys_init | input | 1 | Processor init pin level |
| probe_rdy | input | 1 | Debug probe-ready level |
| addr_hold | input | 1 | Address hold |
| ext_cen | input | 1 | External cache enable |
| cache_req | input | 1 | Internal cacheable request |
| page_wt | input | 1 | Page write-through bit |
| ext_wbwt | input | 1 | External writeback (1) / writethrough (0) |
| fill_ok | output | 1 | Read data may be cached |
| fill_state | output | 2 | Line-state hint: 0 none, 1 Shared, 2 Exclusive |
| sampled | output | 1 | Enable has been captured for this cycle |

## Verification
The checker relies on two assumptions about the inputs:
- `cyc_start` is a single-clock pulse.
- `backoff` is the only way a cycle is abandoned in mid-flight.

With those two assumptions, the claims that a capture persists and that it is cleared at a new start or a backoff can be checked. The bench stays within both rules. It raises every strobe at least one clock after `cyc_start` and holds `cyc_kind`, `cyc_locked` and `pwr_state` steady for the whole cycle. It drives all stimulus on the falling edge.

// File: rtl/fq_pkg.sv
// Shared widths and encodings for the read-fill qualifier.
// Assumes the encodings below match the bus-cycle generator and power controller.
package fq_pkg;
    localparam int KIND_W = 3;
    localparam int PWR_W  = 3;
    localparam int ST_W   = 2;

    typedef enum logic [KIND_W-1:0] {
        KIND_MEM_RD  = 3'd0,
        KIND_MEM_WR  = 3'd1,
        KIND_INQUIRE = 3'd2,
        KIND_IO      = 3'd3,
        KIND_SPECIAL = 3'd4,
        KIND_INTACK  = 3'd5
    } cyc_kind_e;

    typedef enum logic [PWR_W-1:0] {
        PWR_NORMAL   = 3'd0,
        PWR_SMM      = 3'd1,
        PWR_HALT     = 3'd2,
        PWR_SHUTDOWN = 3'd3,
        PWR_STOPGNT  = 3'd4,
        PWR_STOPCLK  = 3'd5
    } pwr_state_e;

    typedef enum logic [ST_W-1:0] {
        FILL_NONE   = 2'd0,
        FILL_SHARED = 2'd1,
        FILL_EXCL   = 2'd2
    } fill_state_e;
endpackage

// File: rtl/fq_gate.sv
// Eligibility gate: decides combinationally whether the current clock may
// capture the cache-enable pin. Assumes cycle attributes are already latched.
module fq_gate
    import fq_pkg::*;
(
    input  logic              cyc_active,
    input  cyc_kind_e         cur_kind,
    input  logic              cur_locked,
    input  logic              cur_ahold_born,
    input  logic [PWR_W-1:0]  pwr_state,
    input  logic              backoff,
    input  logic              hold_ack,
    input  logic              sys_reset,
    input  logic              sys_init,
    input  logic              probe_rdy,
    output logic              elig
);
    logic type_ok;
    logic pwr_ok;
    logic ctl_ok;

    // Only plain memory reads qualify.
    always_comb type_ok = (cur_kind == KIND_MEM_RD) && !cur_locked;

    // Normal and system-management states qualify.
    always_comb begin
        case (pwr_state_e'(pwr_state))
            PWR_NORMAL, PWR_SMM: pwr_ok = 1'b1;
            default:             pwr_ok = 1'b0;
        endcase
    end

    // Live controls block capture; a cycle opened under address hold never qualifies.
    always_comb ctl_ok = !(backoff || hold_ack || sys_reset || sys_init || probe_rdy)
                         && !cur_ahold_born;

    // Combined gate.
    always_comb elig = cyc_active && type_ok && pwr_ok && ctl_ok;
endmodule

// File: rtl/fq_capture.sv
// Capture register: records cycle attributes at cycle start and latches the
// enable pin once per cycle. Assumes strobes never coincide with cyc_start.
module fq_capture
    import fq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cyc_start,
    input  logic [KIND_W-1:0] cyc_kind,
    input  logic              cyc_locked,
    input  logic              addr_hold,
    input  logic              backoff,
    input  logic              strobe,
    input  logic              elig,
    input  logic              ext_cen,
    output logic              cyc_active,
    output cyc_kind_e         cur_kind,
    output logic              cur_locked,
    output logic              cur_ahold_born,
    output logic              smp,
    output logic              cen_q
);
    logic take;

    // A capture happens on the first eligible strobe only.
    always_comb take = strobe && elig && !smp;

    // Attribute and capture state update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cyc_active     <= 1'b0;
            cur_kind       <= KIND_SPECIAL;
            cur_locked     <= 1'b0;
            cur_ahold_born <= 1'b0;
            smp            <= 1'b0;
            cen_q          <= 1'b0;
        end else if (cyc_start) begin
            cyc_active     <= 1'b1;
            cur_kind       <= cyc_kind_e'(cyc_kind);
            cur_locked     <= cyc_locked;
            cur_ahold_born <= addr_hold;
            smp            <= 1'b0;
            cen_q          <= 1'b0;
        end else if (backoff) begin
            smp            <= 1'b0;
            cen_q          <= 1'b0;
        end else if (take) begin
            smp            <= 1'b1;
            cen_q          <= ext_cen;
        end
    end
endmodule

// File: rtl/fq_hint.sv
// Line-state hint: combines the captured enable with the internal and external
// write policy inputs. Assumes policy inputs are valid while sampled is high.
module fq_hint
    import fq_pkg::*;
(
    input  logic            smp,
    input  logic            cen_q,
    input  logic            cache_req,
    input  logic            page_wt,
    input  logic            ext_wbwt,
    output logic            fill_ok,
    output logic [ST_W-1:0] fill_state
);
    // Cacheable only with a captured active enable and an internal request.
    always_comb fill_ok = smp && cen_q && cache_req;

    // Any write-through indication downgrades the fill to Shared.
    always_comb begin
        if (!fill_ok)                  fill_state = FILL_NONE;
        else if (page_wt || !ext_wbwt) fill_state = FILL_SHARED;
        else                           fill_state = FILL_EXCL;
    end
endmodule

// File: rtl/rdfill_qualifier.sv
// Top: read-cycle cacheability sampler. Latches the external cache enable once
// per eligible read and produces a fill flag and line-state hint.
// Assumes cycle attributes are valid in the cyc_start clock.
module rdfill_qualifier
    import fq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cyc_start,
    input  logic [KIND_W-1:0] cyc_kind,
    input  logic              cyc_locked,
    input  logic [PWR_W-1:0]  pwr_state,
    input  logic              data_rdy,
    input  logic              next_addr,
    input  logic              backoff,
    input  logic              hold_ack,
    input  logic              sys_reset,
    input  logic              sys_init,
    input  logic              probe_rdy,
    input  logic              addr_hold,
    input  logic              ext_cen,
    input  logic              cache_req,
    input  logic              page_wt,
    input  logic              ext_wbwt,
    output logic              fill_ok,
    output logic [ST_W-1:0]   fill_state,
    output logic              sampled
);
    logic      strobe;
    logic      elig;
    logic      cyc_active;
    cyc_kind_e cur_kind;
    logic      cur_locked;
    logic      cur_ahold_born;
    logic      smp;
    logic      cen_q;

    // Either the first data-ready or next-address opens the sampling window.
    always_comb strobe = data_rdy || next_addr;

    fq_gate u_gate (
        .cyc_active     (cyc_active),
        .cur_kind       (cur_kind),
        .cur_locked     (cur_locked),
        .cur_ahold_born (cur_ahold_born),
        .pwr_state      (pwr_state),
        .backoff        (backoff),
        .hold_ack       (hold_ack),
        .sys_reset      (sys_reset),
        .sys_init       (sys_init),
        .probe_rdy      (probe_rdy),
        .elig           (elig)
    );

    fq_capture u_cap (
        .clk            (clk),
        .rst_n          (rst_n),
        .cyc_start      (cyc_start),
        .cyc_kind       (cyc_kind),
        .cyc_locked     (cyc_locked),
        .addr_hold      (addr_hold),
        .backoff        (backoff),
        .strobe         (strobe),
        .elig           (elig),
        .ext_cen        (ext_cen),
        .cyc_active     (cyc_active),
        .cur_kind       (cur_kind),
        .cur_locked     (cur_locked),
        .cur_ahold_born (cur_ahold_born),
        .smp            (smp),
        .cen_q          (cen_q)
    );

    fq_hint u_hint (
        .smp        (smp),
        .cen_q      (cen_q),
        .cache_req  (cache_req),
        .page_wt    (page_wt),
        .ext_wbwt   (ext_wbwt),
        .fill_ok    (fill_ok),
        .fill_state (fill_state)
    );

    // Expose the capture flag.
    always_comb sampled = smp;
endmodule

// File: rtl/fq_checker.sv
// Property checker for rdfill_qualifier, bound to every instance of the top.
// Assumes cyc_start is a one-clock pulse and backoff is the only abort.
module fq_checker
    import fq_pkg::*;
(
    input logic            clk,
    input logic            rst_n,
    input logic            cyc_start,
    input logic            backoff,
    input logic            hold_ack,
    input logic            sys_reset,
    input logic            sys_init,
    input logic            probe_rdy,
    input logic            sampled,
    input logic            cen_q,
    input logic            fill_ok,
    input logic [ST_W-1:0] fill_state
);
    // R3: nothing fills without a capture
    a_r3_no_fill_unsampled: assert property (@(posedge clk) disable iff (!rst_n)
        !sampled |-> (!fill_ok && fill_state == FILL_NONE));

    // R4: hint only takes legal codes and agrees with the fill flag
    a_r4_hint_consistent: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_state != 2'd3) && (fill_ok == (fill_state != FILL_NONE)));

    // R2: a capture persists unchanged until a new cycle or a backoff
    a_r2_capture_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (sampled && !cyc_start && !backoff) |=> (sampled && $stable(cen_q)));

    // R9: a new cycle clears the capture
    a_r9_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_start |=> !sampled);

    // R10: backoff discards the capture
    a_r10_backoff_discards: assert property (@(posedge clk) disable iff (!rst_n)
        backoff |=> !sampled);

    // R7: blocking controls prevent a fresh capture
    a_r7_blocked_no_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (!sampled && (hold_ack || sys_reset || sys_init || probe_rdy)) |=> !sampled);
endmodule

bind rdfill_qualifier fq_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cyc_start  (cyc_start),
    .backoff    (backoff),
    .hold_ack   (hold_ack),
    .sys_reset  (sys_reset),
    .sys_init   (sys_init),
    .probe_rdy  (probe_rdy),
    .sampled    (sampled),
    .cen_q      (cen_q),
    .fill_ok    (fill_ok),
    .fill_state (fill_state)
);

// File: tb/sim_rdfill_qualifier.sv
`timescale 1ns/1ps
module sim_rdfill_qualifier;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cyc_start = 1'b0;
    logic [2:0] cyc_kind = 3'd0;
    logic       cyc_locked = 1'b0;
    logic [2:0] pwr_state = 3'd0;
    logic       data_rdy = 1'b0;
    logic       next_addr = 1'b0;
    logic       backoff = 1'b0;
    logic       hold_ack = 1'b0;
    logic       sys_reset = 1'b0;
    logic       sys_init = 1'b0;
    logic       probe_rdy = 1'b0;
    logic       addr_hold = 1'b0;
    logic       ext_cen = 1'b0;
    logic       cache_req = 1'b1;
    logic       page_wt = 1'b0;
    logic       ext_wbwt = 1'b1;
    logic       fill_ok;
    logic [1:0] fill_state;
    logic       sampled;

    int n_chk = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    rdfill_qualifier u0 (
        .clk(clk), .rst_n(rst_n), .cyc_start(cyc_start), .cyc_kind(cyc_kind),
        .cyc_locked(cyc_locked), .pwr_state(pwr_state), .data_rdy(data_rdy),
        .next_addr(next_addr), .backoff(backoff), .hold_ack(hold_ack),
        .sys_reset(sys_reset), .sys_init(sys_init), .probe_rdy(probe_rdy),
        .addr_hold(addr_hold), .ext_cen(ext_cen), .cache_req(cache_req),
        .page_wt(page_wt), .ext_wbwt(ext_wbwt), .fill_ok(fill_ok),
        .fill_state(fill_state), .sampled(sampled)
    );

    // Vector: {exp_state[2], exp_smp, use_na, wbwt, pwt, creq, cen, pwr[3], locked, kind[3]}
    localparam int NV = 17;
    localparam logic [14:0] VEC [NV] = '{
        {2'd2,1'b1,1'b0,1'b1,1'b0,1'b1,1'b1,3'd0,1'b0,3'd0}, // R4 exclusive via data-ready
        {2'd2,1'b1,1'b1,1'b1,1'b0,1'b1,1'b1,3'd0,1'b0,3'd0}, // R2 next-address captures
        {2'd1,1'b1,1'b0,1'b1,1'b1,1'b1,1'b1,3'd0,1'b0,3'd0}, // R4 page write-through
        {2'd1,1'b1,1'b0,1'b0,1'b0,1'b1,1'b1,3'd0,1'b0,3'd0}, // R4 external writethrough
        {2'd0,1'b1,1'b0,1'b1,1'b0,1'b1,1'b0,3'd0,1'b0,3'd0}, // R3 enable low
        {2'd0,1'b1,1'b0,1'b1,1'b0,1'b0,1'b1,3'd0,1'b0,3'd0}, // R4 no internal request
        {2'd2,1'b1,1'b0,1'b1,1'b0,1'b1,1'b1,3'd1,1'b0,3'd0}, // R6 system management
        {2'd0,1'b0,1'b0,1'b1,1'b0,1'b1,1'b1,3'd0,1'b0,3'd1}, // R5 memory write
        {2'd0,1'b0,1'b0,1'b1,1'b0,1'b1,1'b1,3'd0,1'b0,3'd2}, // R5 inquire
        {2'd0,1'b0,1'b0,1'b1,1'b0,1'b1,1'b1,3'd0,1'b0,3'd3}, // R5 I/O
        {2'd0,1'b0,1'b1,1'b1,1'b0,1'b1,1'b1,3'd0,1'b0,3'd4}, // R5 special
        {2'd0,1'b0,1'b0,1'b1,1'b0,1'b1,1'b1,3'd0,1'b0,3'd5}, // R5 interrupt ack
        {2'd0,1'b0,1'b0,1'b1,1'b0,1'b1,1'b1,3'd0,1'b1,3'd0}, // R5 locked read
        {2'd0,1'b0,1'b0,1'b1,1'b0,1'b1,1'b1,3'd2,1'b0,3'd0}, // R6 halt
        {2'd0,1'b0,1'b0,1'b1,1'b0,1'b1,1'b1,3'd3,1'b0,3'd0}, // R6 shutdown
        {2'd0,1'b0,1'b1,1'b1,1'b0,1'b1,1'b1,3'd4,1'b0,3'd0}, // R6 stop grant
        {2'd0,1'b0,1'b0,1'b1,1'b0,1'b1,1'b1,3'd5,1'b0,3'd0}  // R6 stop clock
    };

    task automatic chk(input string tag, input logic [1:0] act, input logic [1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Open a cycle; caller is on a falling edge.
    task automatic start_cyc(input logic [2:0] k, input logic lk);
        cyc_kind = k; cyc_locked = lk; cyc_start = 1'b1;
        @(negedge clk);
        cyc_start = 1'b0;
    endtask

    // One strobe clock with a given enable level.
    task automatic strobe(input logic na, input logic cen);
        ext_cen = cen; data_rdy = !na; next_addr = na;
        @(negedge clk);
        data_rdy = 1'b0; next_addr = 1'b0;
    endtask

    initial begin
        #400000;
        n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 sampled after reset", {1'b0, sampled}, 2'd0);
        chk("R1 fill_ok after reset", {1'b0, fill_ok}, 2'd0);
        chk("R1 fill_state after reset", fill_state, 2'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // Table walk: capture on first strobe, then flip enable on a later beat.
        for (int i = 0; i < NV; i++) begin
            logic [14:0] v;
            v = VEC[i];
            pwr_state = v[6:4]; cache_req = v[8]; page_wt = v[9]; ext_wbwt = v[10];
            start_cyc(v[2:0], v[3]);
            strobe(v[11], v[7]);
            chk($sformatf("R4/R5/R6 vector %0d sampled", i), {1'b0, sampled}, {1'b0, v[12]});
            chk($sformatf("R3/R4 vector %0d state", i), fill_state, v[14:13]);
            strobe(1'b0, !v[7]);
            chk($sformatf("R2 vector %0d later beat", i), fill_state, v[14:13]);
        end
        pwr_state = 3'd0; cache_req = 1'b1; page_wt = 1'b0; ext_wbwt = 1'b1;

        // R2: both strobes together capture once
        start_cyc(3'd0, 1'b0);
        ext_cen = 1'b1; data_rdy = 1'b1; next_addr = 1'b1;
        @(negedge clk);
        data_rdy = 1'b0; next_addr = 1'b0;
        chk("R2 both strobes", fill_state, 2'd2);

        // R9: new cycle clears the capture
        start_cyc(3'd0, 1'b0);
        chk("R9 start clears sampled", {1'b0, sampled}, 2'd0);
        chk("R9 start clears state", fill_state, 2'd0);

        // R7: each blocker prevents capture; later clean strobe captures
        for (int b = 0; b < 5; b++) begin
            start_cyc(3'd0, 1'b0);
            case (b)
                0: hold_ack = 1'b1;
                1: sys_reset = 1'b1;
                2: sys_init = 1'b1;
                3: probe_rdy = 1'b1;
                default: backoff = 1'b1;
            endcase
            strobe(1'b0, 1'b1);
            chk($sformatf("R7 blocker %0d", b), {1'b0, sampled}, 2'd0);
            hold_ack = 1'b0; sys_reset = 1'b0; sys_init = 1'b0; probe_rdy = 1'b0; backoff = 1'b0;
            strobe(1'b0, 1'b1);
            chk($sformatf("R7 after blocker %0d", b), fill_state, 2'd2);
        end

        // R8: hold raised after start still allows sampling
        start_cyc(3'd0, 1'b0);
        addr_hold = 1'b1;
        strobe(1'b0, 1'b1);
        chk("R8 hold after start", fill_state, 2'd2);
        // R8: cycle opened under hold is never sampled
        start_cyc(3'd0, 1'b0);
        strobe(1'b0, 1'b1);
        chk("R8 born under hold", {1'b0, sampled}, 2'd0);
        addr_hold = 1'b0;
        strobe(1'b0, 1'b1);
        chk("R8 born under hold, hold dropped", {1'b0, sampled}, 2'd0);

        // R10: backoff discards capture; restart samples the new level
        start_cyc(3'd0, 1'b0);
        strobe(1'b0, 1'b0);
        chk("R10 first capture", {1'b0, sampled}, 2'd1);
        backoff = 1'b1;
        @(negedge clk);
        backoff = 1'b0;
        chk("R10 discarded", {1'b0, sampled}, 2'd0);
        strobe(1'b1, 1'b1);
        chk("R10 resampled", fill_state, 2'd2);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule